// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver (Master)

This block is a clock-master serial transceiver. Each transfer moves one byte out on `ser_out` and, when reception is enabled, one byte in from `ser_in`, both most significant bit first. The serial clock is made by dividing the system clock by a fixed parameter. It rests high between transfers. Output data changes on the falling serial edge, and input data is sampled on the rising serial edge.

A host drives the block through a small register port with a 2-bit address, single-cycle write and read strobes, and a registered read bus. The register map is:

- Address 0 holds control. Bit 0 enables transmit and bit 1 enables receive.
- Address 1 holds status. Bit 0 is receive-full, bit 1 is transmit-done and bit 2 is overrun.
- Address 2 is the transmit data register.
- Address 3 is the receive data register.

The status flags decide when transfers may start or resume. Enabling from the all-off state arms the unit only if every flag is clear. Reading received data re-arms reception while the receive enable is still set. A pending overrun stops all new activity until the host clears it.

Top module: `ssx_xcvr`

## Requirements
- R1: After reset, control (address 0) reads 0, status (address 1) reads 0, `ser_clk` is high and no transfer runs. Read data appears on `reg_rdata` one cycle after the read strobe.
- R2: The serial clock is high whenever no transfer runs. A transfer begins with a falling edge, then gives 8 periods, each low for CLK_DIV/2 system cycles and then high for CLK_DIV/2 system cycles.
- R3: `ser_out` presents the transmit byte most significant bit first, and it changes only together with a falling edge of `ser_clk`.
- R4: `ser_in` is sampled on each rising edge of `ser_clk`, most significant bit first. The assembled byte is placed in the receive register (address 3) when the transfer ends.
- R5: Receive-full (status bit 0) sets when a reception completes and clears when the host reads address 3.
- R6: In receive-only mode (control = 2'b10), a reception starts whenever the unit is armed, idle and receive-full is 0. Reading address 3 while receive enable is 1 starts the next reception. If control is first written to 0, that read starts nothing.
- R7: Overrun (status bit 2) sets when a reception completes while receive-full is still 1. The receive register keeps the older byte.
- R8: While overrun is 1, no transfer starts. A transfer that is waiting starts once overrun is cleared.
- R9: Overrun clears only when the host writes status with bit 2 = 0. Writing bit 2 = 1 leaves it set. A status write with bit 1 = 0 clears transmit-done.
- R10: With control = 2'b11, writing address 2 starts a full-duplex transfer that sends that byte and captures the received byte in the same transfer. Control = 2'b01 transmits only.
- R11: A control write that changes one nonzero value to a different nonzero value is ignored. Writing 0 is always accepted.
- R12: A control write that enables from 0 arms the unit only if receive-full, transmit-done and overrun are all 0. An unarmed unit starts no transfer until it is disabled and enabled again.
- R13: Transmit-done (status bit 1) sets at the end of a transmitting transfer when no new transmit byte is waiting. A write to address 2 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe, one cycle per read |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, registered |
| ser_clk | output | 1 | Serial clock, idles high |
| ser_out | output | 1 | Serial data out |
| ser_in | input | 1 | Serial data in |

## Verification
A flag that is wrongly set or cleared inside the block shows up at the pins as a serial clock that moves when it should rest, or rests when it should move. The first such event comes one system cycle after the edge where the start decision goes wrong. A corrupted shift register shows as a wrong `ser_out` bit within one half serial period. It also shows as a wrong received byte at the next read of address 3. Flag and arming errors that do not affect the pins become visible at the next status read, one cycle after the read strobe.

// File: rtl/ssx_pkg.sv
package ssx_pkg;
    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_TXD  = 2'd2,
        REG_RXD  = 2'd3
    } ssx_reg_e;

    localparam int unsigned CTRL_TX = 0;
    localparam int unsigned CTRL_RX = 1;
    localparam int unsigned ST_RXF  = 0;
    localparam int unsigned ST_TXD  = 1;
    localparam int unsigned ST_OVR  = 2;
endpackage

// File: rtl/ssx_shifter.sv
module ssx_shifter #(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned CLK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              start_tx_i,
    input  logic              start_rx_i,
    input  logic [DATA_W-1:0] load_i,
    input  logic              ser_in_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              done_tx_o,
    output logic              done_rx_o,
    output logic [DATA_W-1:0] rx_byte_o,
    output logic              ser_clk_o,
    output logic              ser_out_o
);
    localparam int unsigned HALF   = CLK_DIV / 2;
    localparam int unsigned CW     = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int unsigned PHASES = 2 * DATA_W;
    localparam int unsigned HW     = $clog2(PHASES);

    typedef struct packed {
        logic              busy;
        logic              sclk;
        logic [CW-1:0]     cnt;
        logic [HW-1:0]     ph;
        logic [DATA_W-1:0] txs;
        logic [DATA_W-1:0] rxs;
        logic              mtx;
        logic              mrx;
    } sh_t;

    sh_t sh_d, sh_q;
    logic tick, last;

    always_comb begin
        sh_d = sh_q;
        tick = (sh_q.cnt == CW'(HALF - 1));
        last = (sh_q.ph == HW'(PHASES - 1));
        if (sh_q.busy) begin
            if (tick) begin
                sh_d.cnt = '0;
                if (last) begin
                    sh_d.busy = 1'b0;
                    sh_d.sclk = 1'b1;
                end else begin
                    sh_d.ph = sh_q.ph + 1'b1;
                    if (!sh_q.ph[0]) begin
                        sh_d.sclk = 1'b1;
                        sh_d.rxs  = {sh_q.rxs[DATA_W-2:0], ser_in_i};
                    end else begin
                        sh_d.sclk = 1'b0;
                        sh_d.txs  = {sh_q.txs[DATA_W-2:0], 1'b0};
                    end
                end
            end else begin
                sh_d.cnt = sh_q.cnt + 1'b1;
            end
        end else if (start_i) begin
            sh_d.busy = 1'b1;
            sh_d.sclk = 1'b0;
            sh_d.cnt  = '0;
            sh_d.ph   = '0;
            sh_d.txs  = load_i;
            sh_d.mtx  = start_tx_i;
            sh_d.mrx  = start_rx_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q      <= '0;
            sh_q.sclk <= 1'b1;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign busy_o    = sh_q.busy;
    assign done_o    = sh_q.busy && tick && last;
    assign done_tx_o = sh_q.mtx;
    assign done_rx_o = sh_q.mrx;
    assign rx_byte_o = sh_q.rxs;
    assign ser_clk_o = sh_q.sclk;
    assign ser_out_o = sh_q.txs[DATA_W-1];
endmodule

// File: rtl/ssx_regs.sv
module ssx_regs
    import ssx_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              busy_i,
    input  logic              done_i,
    input  logic              done_tx_i,
    input  logic              done_rx_i,
    input  logic [DATA_W-1:0] rx_byte_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              start_o,
    output logic              start_tx_o,
    output logic              start_rx_o,
    output logic [DATA_W-1:0] load_o,
    output logic [1:0]        ctrl_o,
    output logic              rx_full_o,
    output logic              tx_done_o,
    output logic              ovr_o,
    output logic [DATA_W-1:0] rxdata_o
);
    typedef struct packed {
        logic [1:0]        ctrl;
        logic              armed;
        logic              rxf;
        logic              txd;
        logic              ovr;
        logic              txf;
        logic [DATA_W-1:0] txbuf;
        logic [DATA_W-1:0] rxdat;
        logic [DATA_W-1:0] rdata;
    } rg_t;

    rg_t rg_d, rg_q;
    logic wr_ctrl, wr_stat, wr_tx, rd_rx;
    logic mode_tx, mode_rx;
    logic [1:0] new_ctrl;
    logic [DATA_W-1:0] stat_word;

    assign wr_ctrl  = wr_i && (addr_i == REG_CTRL);
    assign wr_stat  = wr_i && (addr_i == REG_STAT);
    assign wr_tx    = wr_i && (addr_i == REG_TXD);
    assign rd_rx    = rd_i && (addr_i == REG_RXD);
    assign mode_tx  = rg_q.ctrl[CTRL_TX];
    assign mode_rx  = rg_q.ctrl[CTRL_RX];
    assign new_ctrl = wdata_i[1:0];

    assign start_o    = !busy_i && rg_q.armed && !rg_q.ovr &&
                        (mode_tx ? rg_q.txf : (mode_rx && !rg_q.rxf));
    assign start_tx_o = mode_tx;
    assign start_rx_o = mode_rx;
    assign load_o     = mode_tx ? rg_q.txbuf : '1;

    always_comb begin
        stat_word         = '0;
        stat_word[ST_RXF] = rg_q.rxf;
        stat_word[ST_TXD] = rg_q.txd;
        stat_word[ST_OVR] = rg_q.ovr;
    end

    always_comb begin
        rg_d = rg_q;
        if (start_o && mode_tx) rg_d.txf = 1'b0;
        if (wr_tx) begin
            rg_d.txbuf = wdata_i;
            rg_d.txf   = 1'b1;
            rg_d.txd   = 1'b0;
        end
        if (wr_stat) begin
            if (!wdata_i[ST_OVR]) rg_d.ovr = 1'b0;
            if (!wdata_i[ST_TXD]) rg_d.txd = 1'b0;
        end
        if (rd_rx) rg_d.rxf = 1'b0;
        if (done_i && done_rx_i) begin
            if (rg_q.rxf && !rd_rx) begin
                rg_d.ovr = 1'b1;
            end else begin
                rg_d.rxf   = 1'b1;
                rg_d.rxdat = rx_byte_i;
            end
        end
        if (done_i && done_tx_i && !rg_q.txf && !wr_tx) rg_d.txd = 1'b1;
        if (wr_ctrl) begin
            if (new_ctrl == 2'b00) begin
                rg_d.ctrl  = 2'b00;
                rg_d.armed = 1'b0;
            end else if (rg_q.ctrl == 2'b00) begin
                rg_d.ctrl  = new_ctrl;
                rg_d.armed = !rg_q.rxf && !rg_q.txd && !rg_q.ovr;
            end
        end
        if (rd_i) begin
            case (addr_i)
                REG_CTRL: rg_d.rdata = {{(DATA_W-2){1'b0}}, rg_q.ctrl};
                REG_STAT: rg_d.rdata = stat_word;
                REG_TXD:  rg_d.rdata = rg_q.txbuf;
                default:  rg_d.rdata = rg_q.rxdat;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    assign rdata_o   = rg_q.rdata;
    assign ctrl_o    = rg_q.ctrl;
    assign rx_full_o = rg_q.rxf;
    assign tx_done_o = rg_q.txd;
    assign ovr_o     = rg_q.ovr;
    assign rxdata_o  = rg_q.rxdat;
endmodule

// File: rtl/ssx_xcvr.sv
module ssx_xcvr #(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned CLK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              ser_clk,
    output logic              ser_out,
    input  logic              ser_in
);
    logic              sh_busy, sh_done, sh_done_tx, sh_done_rx;
    logic [DATA_W-1:0] sh_rx_byte;
    logic              go, go_tx, go_rx;
    logic [DATA_W-1:0] go_load;
    logic [1:0]        st_ctrl;
    logic              st_rxf, st_txd, st_ovr;
    logic [DATA_W-1:0] st_rxdat;

    ssx_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (reg_addr),
        .wr_i      (reg_wr),
        .rd_i      (reg_rd),
        .wdata_i   (reg_wdata),
        .busy_i    (sh_busy),
        .done_i    (sh_done),
        .done_tx_i (sh_done_tx),
        .done_rx_i (sh_done_rx),
        .rx_byte_i (sh_rx_byte),
        .rdata_o   (reg_rdata),
        .start_o   (go),
        .start_tx_o(go_tx),
        .start_rx_o(go_rx),
        .load_o    (go_load),
        .ctrl_o    (st_ctrl),
        .rx_full_o (st_rxf),
        .tx_done_o (st_txd),
        .ovr_o     (st_ovr),
        .rxdata_o  (st_rxdat)
    );

    ssx_shifter #(.DATA_W(DATA_W), .CLK_DIV(CLK_DIV)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (go),
        .start_tx_i(go_tx),
        .start_rx_i(go_rx),
        .load_i    (go_load),
        .ser_in_i  (ser_in),
        .busy_o    (sh_busy),
        .done_o    (sh_done),
        .done_tx_o (sh_done_tx),
        .done_rx_o (sh_done_rx),
        .rx_byte_o (sh_rx_byte),
        .ser_clk_o (ser_clk),
        .ser_out_o (ser_out)
    );
endmodule

// File: rtl/ssx_xcvr_chk.sv
module ssx_xcvr_chk
    import ssx_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        reg_addr,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              ser_clk,
    input logic              ser_out,
    input logic              busy,
    input logic              done,
    input logic [1:0]        ctrl,
    input logic              rx_full,
    input logic              tx_done,
    input logic              ovr,
    input logic [DATA_W-1:0] rxdata
);
    p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ser_clk);

    p_out_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_out != $past(ser_out)) |-> $fell(ser_clk));

    p_rxfull_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == REG_RXD && !done) |=> !rx_full);

    p_ovr_keeps_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $stable(rxdata));

    p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !busy) |=> !busy);

    p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !(reg_wr && reg_addr == REG_STAT && !reg_wdata[ST_OVR])) |=> ovr);

    p_ctrl_lock_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctrl) != 2'b00 && ctrl != 2'b00) |-> (ctrl == $past(ctrl)));

    p_txdone_clear_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == REG_TXD) |=> !tx_done);
endmodule

bind ssx_xcvr ssx_xcvr_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_addr (reg_addr),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_wdata(reg_wdata),
    .ser_clk  (ser_clk),
    .ser_out  (ser_out),
    .busy     (sh_busy),
    .done     (sh_done),
    .ctrl     (st_ctrl),
    .rx_full  (st_rxf),
    .tx_done  (st_txd),
    .ovr      (st_ovr),
    .rxdata   (st_rxdat)
);

// File: tb/tb_ssx_xcvr.sv
module tb_ssx_xcvr;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int DIV = 4;
    localparam int H = DIV / 2;
    localparam int XFER = 2 * DW * H;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic reg_wr = 1'b0;
    logic reg_rd = 1'b0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic ser_clk, ser_out, ser_in;

    int checks = 0;
    int failures = 0;
    bit done_flag = 0;

    assign ser_in = ~ser_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    ssx_xcvr #(.DATA_W(DW), .CLK_DIV(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ser_clk(ser_clk), .ser_out(ser_out), .ser_in(ser_in)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference model of the serial pins and flags
    bit [1:0] m_ctrl;
    bit m_armed, m_rxf, m_txd, m_ovr, m_txf, m_busy, m_mtx, m_mrx;
    bit [DW-1:0] m_txbuf, m_byte;
    int m_t;
    bit e_cmp, e_st, e_wtx, e_wst, e_wct, e_rrx, o_rxf, o_txf, o_txd, o_ovr;
    bit [1:0] o_ctrl;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 0; m_armed = 0; m_rxf = 0; m_txd = 0; m_ovr = 0; m_txf = 0;
            m_busy = 0; m_mtx = 0; m_mrx = 0; m_txbuf = 0; m_byte = 0; m_t = 0;
        end else begin
            e_wtx = reg_wr && reg_addr == 2'd2;
            e_wst = reg_wr && reg_addr == 2'd1;
            e_wct = reg_wr && reg_addr == 2'd0;
            e_rrx = reg_rd && reg_addr == 2'd3;
            o_rxf = m_rxf; o_txf = m_txf; o_txd = m_txd; o_ovr = m_ovr; o_ctrl = m_ctrl;
            e_cmp = m_busy && (m_t == XFER - 1);
            e_st  = !m_busy && m_armed && !m_ovr &&
                    (m_ctrl[0] ? m_txf : (m_ctrl[1] && !m_rxf));
            if (e_cmp) m_busy = 0;
            else if (m_busy) m_t++;
            if (e_st) begin
                m_busy = 1; m_t = 0; m_mtx = o_ctrl[0]; m_mrx = o_ctrl[1];
                m_byte = o_ctrl[0] ? m_txbuf : 8'hFF;
                if (o_ctrl[0]) m_txf = 0;
            end
            if (e_wtx) begin m_txbuf = reg_wdata; m_txf = 1; m_txd = 0; end
            if (e_wst) begin
                if (!reg_wdata[2]) m_ovr = 0;
                if (!reg_wdata[1]) m_txd = 0;
            end
            if (e_rrx) m_rxf = 0;
            if (e_cmp && m_mrx) begin
                if (o_rxf && !e_rrx) m_ovr = 1;
                else m_rxf = 1;
            end
            if (e_cmp && m_mtx && !o_txf && !e_wtx) m_txd = 1;
            if (e_wct) begin
                if (reg_wdata[1:0] == 2'b00) begin m_ctrl = 0; m_armed = 0; end
                else if (o_ctrl == 2'b00) begin
                    m_ctrl = reg_wdata[1:0];
                    m_armed = !o_rxf && !o_txd && !o_ovr;
                end
            end
        end
    end

    // per-cycle pin comparison (R2 clock shape, R3 data order)
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            bit ec;
            ec = m_busy ? (((m_t / H) % 2) == 1) : 1'b1;
            chk(ser_clk == ec, "R2 ser_clk", ser_clk, ec);
            if (m_busy)
                chk(ser_out == m_byte[DW-1 - m_t/(2*H)], "R3 ser_out",
                    ser_out, m_byte[DW-1 - m_t/(2*H)]);
        end
    end

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [DW-1:0] exp, input string tag);
        @(negedge clk); reg_rd = 1; reg_addr = a;
        @(negedge clk); reg_rd = 0;
        chk(reg_rdata == exp, tag, reg_rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        failures++;
        $display("FAIL watchdog all-reqs actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk(ser_clk == 1'b1, "R1 ser_clk idle", ser_clk, 1);
        rd(2'd0, 8'h00, "R1 ctrl reset");
        rd(2'd1, 8'h00, "R1 status reset");

        // R10/R13 transmit only
        wr(2'd0, 8'h01);
        wr(2'd2, 8'hA5);
        idle(XFER + 8);
        rd(2'd1, 8'h02, "R13 tx_done set");
        wr(2'd2, 8'h3C);
        rd(2'd1, 8'h00, "R13 tx_done cleared by write");
        idle(XFER + 8);
        rd(2'd1, 8'h02, "R10 tx-only end, no rx_full");

        // R11 direct mode change ignored
        wr(2'd0, 8'h03);
        rd(2'd0, 8'h01, "R11 ctrl unchanged");

        // R12 enabling with a flag set does not arm
        wr(2'd0, 8'h00);
        wr(2'd0, 8'h03);
        wr(2'd2, 8'h5A);
        idle(XFER + 8);
        rd(2'd1, 8'h00, "R12 not armed, no transfer");

        // R10 re-enable with flags clear: pending byte goes out, full duplex
        wr(2'd0, 8'h00);
        wr(2'd0, 8'h03);
        idle(XFER + 8);
        rd(2'd1, 8'h03, "R10 duplex flags");
        rd(2'd3, 8'hA5, "R4 received byte");
        rd(2'd1, 8'h02, "R5 rx_full cleared by read");
        wr(2'd2, 8'h81);
        idle(XFER + 8);
        rd(2'd1, 8'h03, "R5 rx_full set");

        // R7 overrun keeps older byte
        wr(2'd2, 8'h0F);
        idle(XFER + 8);
        rd(2'd1, 8'h07, "R7 overrun set");
        rd(2'd3, 8'h7E, "R7 old byte kept");

        // R8 freeze, R9 clear rule
        wr(2'd2, 8'h33);
        idle(XFER + 8);
        chk(ser_clk == 1'b1, "R8 no transfer while overrun", ser_clk, 1);
        rd(2'd1, 8'h04, "R8 frozen status");
        wr(2'd1, 8'h04);
        rd(2'd1, 8'h04, "R9 write 1 keeps overrun");
        wr(2'd1, 8'h00);
        idle(XFER + 8);
        rd(2'd1, 8'h03, "R8 resumed after clear");
        rd(2'd3, 8'hCC, "R4 resumed byte");

        // R6 receive-only re-arm
        wr(2'd1, 8'h00);
        rd(2'd1, 8'h00, "R9 tx_done cleared by status write");
        wr(2'd0, 8'h00);
        wr(2'd0, 8'h02);
        idle(XFER + 8);
        rd(2'd1, 8'h01, "R6 rx-only reception done");
        rd(2'd3, 8'h00, "R6 rx-only byte");
        rd(2'd1, 8'h00, "R6 read re-armed");
        chk(ser_clk == 1'b0, "R6 next reception running", ser_clk, 0);
        idle(XFER + 8);
        rd(2'd1, 8'h01, "R6 second reception done");
        wr(2'd0, 8'h00);
        rd(2'd3, 8'h00, "R6 final read");
        idle(XFER + 8);
        chk(ser_clk == 1'b1, "R6 no reception after disable", ser_clk, 1);
        rd(2'd1, 8'h00, "R6 status after disable");

        finish_run();
    end
endmodule